// File: doc/BRIEF.md
# TDM Channel Selector with Subframe Boundary Interrupt

This block follows the position of the current element inside a time-division multiplexed frame. It splits the frame into subframes of a fixed number of elements and decides, for each element, whether that channel takes part. Two partitions, A and B, each hold a subframe pointer and a per-element enable mask. Even subframes are served by partition A and odd subframes by partition B. A channel is enabled only when the pointer of the serving partition names the current subframe and the mask bit for the element's offset is set.

Every crossing from one subframe into the next can raise a two-cycle interrupt pulse. Software uses this pulse to read back the subframe index and the active partition, then retargets the partition that is idle. Writes go to a pending copy and reach the active copy only at a boundary, so a subframe in progress is never disturbed. Receive and transmit paths each use their own instance, with their own enable and interrupt-mode field.

Two state machines drive the block. The position machine has the states POS_OFF (multichannel disabled, counters held at zero) and POS_RUN (counting). Its transitions are OFF->RUN when `mc_en` is high and RUN->OFF when `mc_en` is low. The interrupt machine has the states IRQ_IDLE, IRQ_HI1 and IRQ_HI2. Its transitions are IDLE->HI1 on a qualified crossing, HI1->HI2, HI2->IDLE, and HI2->HI1 on a new qualified crossing. Any state goes to IDLE when `mc_en` is low.

Top module: `tdm_chan_sel`

## Requirements
- R1: While running, each `elem_done` pulse advances the element offset by one. A pulse on the last element (offset ELEMS-1) returns the offset to 0 and advances `sub_idx` by one, wrapping from SUBS-1 back to 0.
- R2: A `fsync` pulse returns the element offset and `sub_idx` to 0 at the next edge. It takes priority over an `elem_done` in the same cycle and never raises the interrupt.
- R3: `part_b` is 0 while `sub_idx` is even (partition A serves) and 1 while it is odd (partition B serves).
- R4: `chan_en` is 1 exactly when the block is running, the active pointer of the serving partition equals `sub_idx`, and bit [element offset] of that partition's active mask is 1.
- R5: While running, a write (`a_wr`/`b_wr` high for one cycle) changes the active pointer and mask only at the next subframe crossing or `fsync`. While `mc_en` is low, a write takes effect at the next edge.
- R6: A subframe crossing with `int_mode` equal to 2'b01 drives `bnd_irq` high for exactly the two cycles that follow the crossing edge. Any other `int_mode` value produces no pulse.
- R7: When `mc_en` is low, then from the next edge on `sub_idx` is 0, `chan_en` is 0 and `bnd_irq` is 0, whatever `int_mode` holds. A pulse in progress is cut short.
- R8: After reset, `chan_en`, `bnd_irq`, `part_b` and `sub_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_en | input | 1 | Multichannel mode enable |
| int_mode | input | 2 | Interrupt mode; 2'b01 selects boundary pulses |
| fsync | input | 1 | Frame start strobe |
| elem_done | input | 1 | One element finished |
| a_wr | input | 1 | Write strobe for partition A |
| a_ptr | input | SW | Subframe pointer for partition A |
| a_mask | input | ELEMS | Element enable mask for partition A |
| b_wr | input | 1 | Write strobe for partition B |
| b_ptr | input | SW | Subframe pointer for partition B |
| b_mask | input | ELEMS | Element enable mask for partition B |
| chan_en | output | 1 | Current channel is selected |
| sub_idx | output | SW | Current subframe index |
| part_b | output | 1 | Serving partition (0 = A, 1 = B) |
| bnd_irq | output | 1 | Subframe boundary interrupt pulse |

## Verification
The bench uses the defaults ELEMS = 16 and SUBS = 8, which make a full 128-channel frame. With these values the wrap of the subframe index from 7 to 0 is reached within a few hundred element strobes. The 16-bit masks let the bench check every element offset of a subframe against a known pattern. Because SUBS is a power of two, the wrap compare and the width of the 3-bit index are tested at the same boundary.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
    typedef enum logic {
        POS_OFF,
        POS_RUN
    } pos_state_e;

    typedef enum logic [1:0] {
        IRQ_IDLE,
        IRQ_HI1,
        IRQ_HI2
    } irq_state_e;

    localparam logic [1:0] IRQ_MODE_BOUNDARY = 2'b01;
endpackage

// File: rtl/tdm_pos_ctr.sv
module tdm_pos_ctr
    import tdm_sel_pkg::*;
#(
    parameter int ELEMS = 16,
    parameter int SUBS  = 8,
    localparam int EW   = $clog2(ELEMS),
    localparam int SW   = $clog2(SUBS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mc_en,
    input  logic          fsync,
    input  logic          elem_done,
    output logic          run,
    output logic [EW-1:0] elem_idx,
    output logic [SW-1:0] sub_idx,
    output logic          crossing
);
    localparam logic [EW-1:0] LAST_E = EW'(ELEMS - 1);
    localparam logic [SW-1:0] LAST_S = SW'(SUBS - 1);

    pos_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= POS_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            POS_OFF: if (mc_en)  state_nxt = POS_RUN;
            POS_RUN: if (!mc_en) state_nxt = POS_OFF;
            default: state_nxt = POS_OFF;
        endcase
    end

    always_comb begin
        run      = (state == POS_RUN);
        crossing = run && mc_en && elem_done && !fsync && (elem_idx == LAST_E);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elem_idx <= '0;
            sub_idx  <= '0;
        end else if (!mc_en || fsync || !run) begin
            elem_idx <= '0;
            sub_idx  <= '0;
        end else if (elem_done) begin
            if (elem_idx == LAST_E) begin
                elem_idx <= '0;
                sub_idx  <= (sub_idx == LAST_S) ? '0 : sub_idx + 1'b1;
            end else begin
                elem_idx <= elem_idx + 1'b1;
            end
        end
    end

    AST_FSYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (elem_idx == '0 && sub_idx == '0)); // R2

    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        crossing |=> (elem_idx == '0 &&
                      sub_idx == (($past(sub_idx) == LAST_S) ? '0 : $past(sub_idx) + 1'b1))); // R1

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_en |=> (sub_idx == '0 && !run)); // R7
endmodule

// File: rtl/tdm_part_bank.sv
module tdm_part_bank #(
    parameter int ELEMS = 16,
    parameter int SW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SW-1:0]    ptr_in,
    input  logic [ELEMS-1:0] mask_in,
    input  logic             reload,
    output logic [SW-1:0]    act_ptr,
    output logic [ELEMS-1:0] act_mask
);
    logic [SW-1:0]    pend_ptr;
    logic [ELEMS-1:0] pend_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_ptr  <= '0;
            pend_mask <= '0;
        end else if (wr) begin
            pend_ptr  <= ptr_in;
            pend_mask <= mask_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_ptr  <= '0;
            act_mask <= '0;
        end else if (reload) begin
            act_ptr  <= wr ? ptr_in  : pend_ptr;
            act_mask <= wr ? mask_in : pend_mask;
        end
    end

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> ($stable(act_ptr) && $stable(act_mask))); // R5
endmodule

// File: rtl/tdm_irq_gen.sv
module tdm_irq_gen
    import tdm_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mc_en,
    input  logic [1:0] int_mode,
    input  logic       crossing,
    output logic       irq
);
    irq_state_e state, state_nxt;
    logic       fire;

    always_comb fire = crossing && (int_mode == IRQ_MODE_BOUNDARY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = IRQ_IDLE;
        unique case (state)
            IRQ_IDLE: state_nxt = fire ? IRQ_HI1 : IRQ_IDLE;
            IRQ_HI1:  state_nxt = fire ? IRQ_HI1 : IRQ_HI2;
            IRQ_HI2:  state_nxt = fire ? IRQ_HI1 : IRQ_IDLE;
            default:  state_nxt = IRQ_IDLE;
        endcase
        if (!mc_en) state_nxt = IRQ_IDLE;
    end

    always_comb irq = (state != IRQ_IDLE);

    AST_PULSE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && mc_en) |=> irq); // R6

    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IRQ_HI2 && !fire) |=> !irq); // R6

    AST_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(int_mode) == IRQ_MODE_BOUNDARY)); // R6
endmodule

// File: rtl/tdm_chan_sel.sv
module tdm_chan_sel
    import tdm_sel_pkg::*;
#(
    parameter int ELEMS = 16,
    parameter int SUBS  = 8,
    localparam int EW   = $clog2(ELEMS),
    localparam int SW   = $clog2(SUBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_en,
    input  logic [1:0]       int_mode,
    input  logic             fsync,
    input  logic             elem_done,
    input  logic             a_wr,
    input  logic [SW-1:0]    a_ptr,
    input  logic [ELEMS-1:0] a_mask,
    input  logic             b_wr,
    input  logic [SW-1:0]    b_ptr,
    input  logic [ELEMS-1:0] b_mask,
    output logic             chan_en,
    output logic [SW-1:0]    sub_idx,
    output logic             part_b,
    output logic             bnd_irq
);
    logic             run;
    logic             crossing;
    logic             reload;
    logic [EW-1:0]    elem_idx;
    logic [SW-1:0]    act_ptr   [2];
    logic [ELEMS-1:0] act_mask  [2];
    logic             wr_v      [2];
    logic [SW-1:0]    ptr_v     [2];
    logic [ELEMS-1:0] mask_v    [2];

    tdm_pos_ctr #(.ELEMS(ELEMS), .SUBS(SUBS)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_en     (mc_en),
        .fsync     (fsync),
        .elem_done (elem_done),
        .run       (run),
        .elem_idx  (elem_idx),
        .sub_idx   (sub_idx),
        .crossing  (crossing)
    );

    always_comb begin
        reload    = !run || fsync || crossing;
        wr_v[0]   = a_wr;
        ptr_v[0]  = a_ptr;
        mask_v[0] = a_mask;
        wr_v[1]   = b_wr;
        ptr_v[1]  = b_ptr;
        mask_v[1] = b_mask;
    end

    for (genvar p = 0; p < 2; p++) begin : g_part
        tdm_part_bank #(.ELEMS(ELEMS), .SW(SW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_v[p]),
            .ptr_in   (ptr_v[p]),
            .mask_in  (mask_v[p]),
            .reload   (reload),
            .act_ptr  (act_ptr[p]),
            .act_mask (act_mask[p])
        );
    end

    tdm_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_en    (mc_en),
        .int_mode (int_mode),
        .crossing (crossing),
        .irq      (bnd_irq)
    );

    always_comb begin
        part_b  = sub_idx[0];
        chan_en = run && (act_ptr[part_b] == sub_idx) && act_mask[part_b][elem_idx];
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_en |=> (!chan_en && !bnd_irq)); // R7

    AST_SEL_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |-> $past(mc_en)); // R4
endmodule

// File: tb/sim_tdm_chan_sel.sv
`timescale 1ns/1ps
module sim_tdm_chan_sel;
    localparam int ELEMS = 16;
    localparam int SUBS  = 8;
    localparam int SW    = $clog2(SUBS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mc_en = 1'b0;
    logic [1:0]       int_mode = 2'b00;
    logic             fsync = 1'b0;
    logic             elem_done = 1'b0;
    logic             a_wr = 1'b0;
    logic [SW-1:0]    a_ptr = '0;
    logic [ELEMS-1:0] a_mask = '0;
    logic             b_wr = 1'b0;
    logic [SW-1:0]    b_ptr = '0;
    logic [ELEMS-1:0] b_mask = '0;
    logic             chan_en;
    logic [SW-1:0]    sub_idx;
    logic             part_b;
    logic             bnd_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tdm_chan_sel #(.ELEMS(ELEMS), .SUBS(SUBS)) u0 (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .int_mode(int_mode),
        .fsync(fsync), .elem_done(elem_done),
        .a_wr(a_wr), .a_ptr(a_ptr), .a_mask(a_mask),
        .b_wr(b_wr), .b_ptr(b_ptr), .b_mask(b_mask),
        .chan_en(chan_en), .sub_idx(sub_idx), .part_b(part_b), .bnd_irq(bnd_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic step_elem();
        elem_done = 1'b1;
        cyc();
        elem_done = 1'b0;
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) step_elem();
    endtask

    task automatic t_reset();
        chk("R8 chan_en", chan_en, 0);
        chk("R8 bnd_irq", bnd_irq, 0);
        chk("R8 part_b", part_b, 0);
        chk("R8 sub_idx", sub_idx, 0);
    endtask

    // A: ptr 0 mask 0005, B: ptr 1 mask 8001; walk subframe 0 then cross
    task automatic t_walk();
        a_ptr = 3'd0; a_mask = 16'h0005; a_wr = 1'b1;
        b_ptr = 3'd1; b_mask = 16'h8001; b_wr = 1'b1;
        cyc();
        a_wr = 1'b0; b_wr = 1'b0;
        mc_en = 1'b1; int_mode = 2'b01;
        cyc();
        for (int k = 0; k < ELEMS; k++) begin
            chk("R4 mask A walk", chan_en, (16'h0005 >> k) & 1);
            chk("R3 part A on even", part_b, 0);
            if (k < ELEMS - 1) step_elem();
        end
        chk("R6 no pulse before crossing", bnd_irq, 0);
        step_elem();
        chk("R1 sub advances", sub_idx, 1);
        chk("R3 part B on odd", part_b, 1);
        chk("R4 B element 0", chan_en, 1);
        chk("R6 pulse cycle 1", bnd_irq, 1);
        cyc();
        chk("R6 pulse cycle 2", bnd_irq, 1);
        cyc();
        chk("R6 pulse ends", bnd_irq, 0);
    endtask

    task automatic t_deferred();
        b_ptr = 3'd3; b_mask = 16'hFFFF; b_wr = 1'b1;
        cyc();
        b_wr = 1'b0;
        chk("R5 element 0 unchanged", chan_en, 1);
        step_elem();
        chk("R5 old mask kept mid subframe", chan_en, 0);
        advance(ELEMS - 1);
        chk("R1 sub 2", sub_idx, 2);
        chk("R4 A pointer mismatch", chan_en, 0);
        advance(ELEMS);
        chk("R1 sub 3", sub_idx, 3);
        chk("R5 new B active after crossing", chan_en, 1);
        step_elem();
        chk("R5 new B element 1", chan_en, 1);
        advance(ELEMS - 1);
    endtask

    task automatic t_mode_off();
        int_mode = 2'b00;
        advance(ELEMS);
        chk("R1 sub 5", sub_idx, 5);
        chk("R6 mode 00 no pulse", bnd_irq, 0);
        cyc();
        chk("R6 mode 00 still quiet", bnd_irq, 0);
        int_mode = 2'b10;
        advance(ELEMS);
        chk("R6 mode 10 no pulse", bnd_irq, 0);
        int_mode = 2'b01;
    endtask

    task automatic t_wrap();
        advance(ELEMS);
        chk("R1 sub 7", sub_idx, 7);
        chk("R6 pulse at 6->7", bnd_irq, 1);
        advance(ELEMS);
        chk("R1 wrap to 0", sub_idx, 0);
        chk("R3 part A after wrap", part_b, 0);
        chk("R6 pulse at wrap", bnd_irq, 1);
        cyc();
        cyc();
    endtask

    task automatic t_fsync();
        advance(ELEMS + 5);
        chk("R1 mid sub 1", sub_idx, 1);
        fsync = 1'b1;
        cyc();
        fsync = 1'b0;
        chk("R2 fsync sub 0", sub_idx, 0);
        chk("R4 element 0 after fsync", chan_en, 1);
        chk("R2 fsync no pulse", bnd_irq, 0);
        cyc();
        chk("R2 fsync no pulse later", bnd_irq, 0);
        advance(ELEMS - 1);
        a_ptr = 3'd0; a_mask = 16'h0002; a_wr = 1'b1;
        cyc();
        a_wr = 1'b0;
        chk("R5 A write waits", chan_en, 0);
        fsync = 1'b1; elem_done = 1'b1;
        cyc();
        fsync = 1'b0; elem_done = 1'b0;
        chk("R2 fsync wins over last element", sub_idx, 0);
        chk("R2 fsync wins no pulse", bnd_irq, 0);
        chk("R5 fsync loads A mask", chan_en, 0);
        step_elem();
        chk("R5 new A element 1", chan_en, 1);
    endtask

    task automatic t_disable();
        advance(ELEMS - 1);
        chk("R6 pulse at 0->1", bnd_irq, 1);
        chk("R1 sub 1 before disable", sub_idx, 1);
        mc_en = 1'b0;
        cyc();
        chk("R7 pulse cut", bnd_irq, 0);
        chk("R7 sub zero", sub_idx, 0);
        chk("R7 chan off", chan_en, 0);
        for (int i = 0; i < 20; i++) begin
            step_elem();
            chk("R7 idle sub", sub_idx, 0);
            chk("R7 idle irq", bnd_irq, 0);
        end
        b_ptr = 3'd0; b_mask = 16'h0000; b_wr = 1'b1;
        cyc();
        b_wr = 1'b0;
        chk("R7 chan off while disabled", chan_en, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cyc();
        cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_walk();
        t_deferred();
        t_mode_off();
        t_wrap();
        t_fsync();
        t_disable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule